// File: doc/BRIEF.md
# Configuration Space Device Scanner

This block walks the primary bus of a configuration space to find one particular device. For each of 32 device slots, in ascending order, it issues a single dword configuration read to function 0. It then compares the returned word against a search key. The key is either a packed device/vendor identifier pair or a 24-bit class code. The block counts the hits and stops at the hit whose ordinal equals the requested index, so software can list every instance of a device by asking for index 0, 1, 2 and so on.

A search begins with a one-cycle start command that carries the mode, the key and the index. The scanner drives a request/acknowledge read port and accepts any read latency. When the search ends it pulses `done` for one cycle, together with a status code and the bus/devfn location of the hit. In identifier mode, a vendor value of all ones is refused at once and no bus reads are made.

Top module: `cfg_scanner`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are 0, `status` is 2'b00 and `found_devfn` is 0.
- R2: Each scan reads slots 0, 1, 2, … in ascending order, one read per slot. Every read uses bus 0 and devfn = slot << 3, so bits [2:0] are 0. The offset is 0x00 in identifier mode (`mode`=0) and 0x08 in class mode (`mode`=1).
- R3: In identifier mode a slot matches when the read word equals `match_val` exactly. The device ID is in bits [31:16] and the vendor ID is in bits [15:0].
- R4: In identifier mode with `match_val[15:0]` = 16'hFFFF, the cycle after the start command has `done`=1 and `status`=2'b10. No read is issued and `busy` stays 0.
- R5: In class mode a slot matches when read word bits [31:8] equal `match_val[23:0]`. Bits [7:0] of the read word and bits [31:24] of `match_val` are ignored.
- R6: Matches are counted from 0. The result is the slot of the match whose count equals `index`. Earlier matches are passed over and the scan continues.
- R7: On success, `status`=2'b00, `found_bus`=0 and `found_devfn` = slot << 3 of the selected match. The scan stops after that slot's read.
- R8: If fewer than `index`+1 slots match, all 32 slots are read, and then `done` is raised with `status`=2'b01.
- R9: A read returning 32'hFFFFFFFF, as from an empty slot, is compared like any other value. It does not end the scan.
- R10: `busy` is 1 from the cycle after an accepted start until the cycle `done` is raised. A start command while `busy` is 1 is ignored and does not change the running search or its result.
- R11: `rd_req` stays high, with a stable address, until the cycle in which `rd_ack` is seen high. `rd_data` is captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle search command |
| mode | input | 1 | 0 = identifier match, 1 = class match |
| match_val | input | 32 | Search key ({device,vendor} or class in [23:0]) |
| index | input | 16 | Ordinal of the wanted match |
| rd_req | output | 1 | Configuration read request |
| rd_bus | output | 8 | Bus number of the read |
| rd_devfn | output | 8 | Device/function of the read |
| rd_offset | output | 8 | Register offset of the read |
| rd_ack | input | 1 | Read completion, one cycle |
| rd_data | input | 32 | Read data, valid with `rd_ack` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| status | output | 2 | 00 found, 01 not found, 10 bad vendor |
| found_bus | output | 8 | Bus of the match |
| found_devfn | output | 8 | Devfn of the match |

## Verification
A refused vendor produces `done` on the first clock edge after the start is sampled. A slot read is compared one edge after its acknowledge, and `done` follows on that same compare edge. As a result, a search ends a fixed two cycles plus the read latency per slot after the start, and the count of reads is slot+1. Inputs and the modelled read responder change only on falling edges. The bench waits for `done` on falling edges and reads status and location in the same half cycle. Each acknowledged read is also checked against the slot the bench expects next.

// File: rtl/cfg_scanner.sv
module cfg_scanner #(
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [DATA_W-1:0] match_val,
  input  logic [IDX_W-1:0]  index,
  output logic              rd_req,
  output logic [7:0]        rd_bus,
  output logic [7:0]        rd_devfn,
  output logic [7:0]        rd_offset,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [7:0]        found_bus,
  output logic [7:0]        found_devfn
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_CMP} state_t;

  state_t              state;
  logic                mode_q;
  logic [DATA_W-1:0]   key_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    hits;
  logic [SLOT_W-1:0]   slot;
  logic [DATA_W-1:0]   data_q;

  wire accept  = start && state == S_IDLE;
  wire bad_ven = !mode && match_val[15:0] == 16'hFFFF;
  wire hit     = mode_q ? (data_q[DATA_W-1:8] == key_q[DATA_W-9:0]) : (data_q == key_q);

  assign busy      = state != S_IDLE;
  assign rd_req    = state == S_REQ;
  assign rd_bus    = 8'h00;
  assign rd_devfn  = 8'(slot) << 3;
  assign rd_offset = mode_q ? 8'h08 : 8'h00;
  assign found_bus = 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      mode_q      <= 1'b0;
      key_q       <= '0;
      idx_q       <= '0;
      hits        <= '0;
      slot        <= '0;
      data_q      <= '0;
      done        <= 1'b0;
      status      <= 2'b00;
      found_devfn <= 8'h00;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (bad_ven) begin
            done   <= 1'b1;
            status <= 2'b10;
          end else begin
            mode_q <= mode;
            key_q  <= match_val;
            idx_q  <= index;
            hits   <= '0;
            slot   <= '0;
            state  <= S_REQ;
          end
        end
        S_REQ: if (rd_ack) begin
          data_q <= rd_data;
          state  <= S_CMP;
        end
        S_CMP: begin
          if (hit && hits == idx_q) begin
            done        <= 1'b1;
            status      <= 2'b00;
            found_devfn <= rd_devfn;
            state       <= S_IDLE;
          end else if (slot == LAST) begin
            done   <= 1'b1;
            status <= 2'b01;
            state  <= S_IDLE;
          end else begin
            if (hit) hits <= hits + 1'b1;
            slot  <= slot + 1'b1;
            state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_scanner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mode,
  input logic [31:0] match_val,
  input logic        rd_req,
  input logic        rd_ack,
  input logic [7:0]  rd_bus,
  input logic [7:0]  rd_devfn,
  input logic [7:0]  rd_offset,
  input logic        busy,
  input logic        done,
  input logic [1:0]  status
);
  AST_BAD_VENDOR: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !mode && match_val[15:0] == 16'hFFFF |=> done && status == 2'b10 && !busy); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_devfn) && $stable(rd_offset)); // R11
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_bus == 8'h00 && rd_devfn[2:0] == 3'b000 && (rd_offset == 8'h00 || rd_offset == 8'h08)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req); // R10
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done); // R10
endmodule

bind cfg_scanner cfg_scanner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .match_val(match_val),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_bus(rd_bus), .rd_devfn(rd_devfn),
  .rd_offset(rd_offset), .busy(busy), .done(done), .status(status)
);

// File: tb/cfg_scanner_test.sv
`timescale 1ns/1ps
module cfg_scanner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, rd_ack = 1'b0;
  logic [31:0] match_val = '0, rd_data = '0;
  logic [15:0] index = '0;
  logic rd_req, busy, done;
  logic [7:0] rd_bus, rd_devfn, rd_offset, found_bus, found_devfn;
  logic [1:0] status;

  int vectors = 0, errors = 0;
  int lat = 0, wcnt = 0, exp_slot = 0, reads = 0;
  logic [31:0] id_mem [32];
  logic [31:0] cls_mem [32];

  always #4 clk = ~clk;

  cfg_scanner uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read responder (R2, R11)
  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      if (wcnt >= lat) begin
        chk("R2 slot order", 32'(rd_devfn), 32'(exp_slot << 3));
        chk("R2 offset", 32'(rd_offset), mode_sel ? 32'h8 : 32'h0);
        rd_ack  = 1'b1;
        rd_data = mode_sel ? cls_mem[rd_devfn >> 3] : id_mem[rd_devfn >> 3];
        exp_slot++;
        reads++;
        wcnt = 0;
      end else wcnt++;
    end else begin
      rd_ack = 1'b0;
      wcnt = 0;
    end
  end

  logic mode_sel = 1'b0;

  task automatic model(input logic m, input logic [31:0] v, input int idx,
                       output int st, output int slot);
    int n = 0;
    st = 1; slot = 0;
    if (!m && v[15:0] == 16'hFFFF) begin st = 2; return; end
    for (int s = 0; s < 32; s++) begin
      logic h;
      h = m ? (cls_mem[s][31:8] == v[23:0]) : (id_mem[s] == v);
      if (h) begin
        if (n == idx) begin st = 0; slot = s; return; end
        n++;
      end
    end
  endtask

  task automatic run(input logic m, input logic [31:0] v, input int idx,
                     input int l, input bit poke);
    int st, slot, guard;
    model(m, v, idx, st, slot);
    lat = l; exp_slot = 0; reads = 0; mode_sel = m;
    @(negedge clk);
    start = 1'b1; mode = m; match_val = v; index = 16'(idx);
    @(negedge clk);
    start = 1'b0;
    if (st != 2) chk("R10 busy after start", 32'(busy), 1);
    guard = 0;
    while (!done && guard < 3000) begin
      if (poke && guard == 5) begin
        start = 1'b1; mode = ~m; match_val = 32'h0; index = '0;
      end else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    if (!done) begin
      errors++; vectors++;
      $display("FAIL R10 watchdog actual=busy expected=done");
      return;
    end
    chk("R10 busy low at done", 32'(busy), 0);
    chk(st == 2 ? "R4 status" : (st == 1 ? "R8 status" : "R7 status"), 32'(status), 32'(st));
    if (st == 0) begin
      chk("R7 devfn R6 R3 R5", 32'(found_devfn), 32'(slot << 3));
      chk("R7 bus", 32'(found_bus), 0);
      chk("R6 read count", reads, slot + 1);
    end else if (st == 1) chk("R8 read count R9", reads, 32);
    else chk("R4 no reads", reads, 0);
    @(negedge clk);
    chk("R10 done is a pulse", 32'(done), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 32; s++) begin
      id_mem[s]  = (s % 4 == 1) ? 32'hFFFF_FFFF : {16'h1000 + 16'(s), 16'h8086};
      cls_mem[s] = (s % 4 == 1) ? 32'hFFFF_FFFF : {8'h03, 8'h00, 8'(s % 3), 8'(s)};
    end
    foreach (id_mem[s]) if (s == 3 || s == 7 || s == 20 || s == 31) id_mem[s] = 32'h1234_ABCD;
    cls_mem[6]  = 32'h0200_0011;
    cls_mem[22] = 32'h0200_0022;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 rd_req", 32'(rd_req), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 devfn", 32'(found_devfn), 0);
    rst_n = 1'b1;
    // R3 R6 R7 R8: identifier mode, all indices, varied latency
    for (int i = 0; i < 6; i++) run(1'b0, 32'h1234_ABCD, i, i % 3, 1'b0);
    for (int s = 0; s < 32; s += 5) run(1'b0, id_mem[s], 0, 0, 1'b0);
    run(1'b0, 32'h5555_8086, 0, 1, 1'b0);
    // R4 refused vendor
    run(1'b0, 32'h1234_FFFF, 0, 0, 1'b0);
    run(1'b0, 32'hFFFF_FFFF, 2, 0, 1'b0);
    // R5 class mode, low byte and top byte ignored
    for (int i = 0; i < 3; i++) run(1'b1, 32'hAB02_0000, i, 2, 1'b0);
    for (int k = 0; k < 3; k++) run(1'b1, {8'h77, 8'h03, 8'h00, 8'(k)}, 4, 0, 1'b0);
    // R9 all-ones read data is an ordinary value
    for (int i = 0; i < 3; i++) run(1'b1, 32'h00FF_FFFF, i, 0, 1'b0);
    // R10 start while busy ignored
    run(1'b0, 32'h1234_ABCD, 2, 1, 1'b1);
    run(1'b1, 32'h0002_0000, 1, 0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule